// File: doc/BRIEF.md
# Strobed Serial Codec Write Controller

This block lets a host send one 16-bit word to an external codec over a four-wire serial link by writing a single 32-bit control register. The low half of the register holds the word to send. The bit just above the payload is a start strobe when written and a busy flag when read. The bit above that is an enable that must be set for any transfer to run. The remaining upper bits are plain storage: they keep whatever the host writes.

The host first writes its word with the strobe clear, then writes the same word with the strobe set. The 0-to-1 change of the strobe, judged against the previous host write, launches the shift-out. The host then polls until the strobe reads 0 and finally writes the word once more with the strobe clear. The serial side runs in SPI mode 0: the clock idles low, the MSB goes first, data changes only while the clock is low, and the active-low select stays low for exactly 16 serial clock periods. The serial clock is the system clock divided by an even parameter, so a transfer takes 16 × CLK_DIV system cycles, far below the host's polling window of about 1 ms.

The register port is a plain single-cycle write strobe with a combinational readback. It has no valid/ready handshake and applies no back-pressure: every write is accepted in the cycle it is presented. The serial outputs carry no flow control either.

Top module: `spi_strobe_ctrl`

## Requirements
- R1: The 16 bits of wr_data[15:0] from the launching write leave on spi_mosi MSB first, one bit per serial clock period.
- R2: spi_sclk is low whenever spi_cs_n is high. spi_mosi changes only while spi_sclk is low, and the first bit is valid before the first rising spi_sclk edge.
- R3: spi_cs_n is low for exactly 16 rising spi_sclk edges per transfer. rd_data[16] reads 1 exactly while spi_cs_n is low.
- R4: One serial clock period is CLK_DIV system cycles, so spi_cs_n stays low for 16 × CLK_DIV cycles (64 at the default CLK_DIV = 4).
- R5: A transfer starts only when a write has bit 16 = 1 and bit 17 = 1 and the previous host write had bit 16 = 0. Writing bit 16 = 1 again without clearing it first starts nothing.
- R6: A write with bit 16 = 1 and bit 17 = 0 starts no transfer, and bit 16 then reads 0.
- R7: When a transfer completes, the hardware clears rd_data[16] and leaves every other register bit unchanged.
- R8: Bits 31:17 and 15:0 read back exactly as last written.
- R9: A write during a transfer updates the stored bits other than 16 and does not change the bits being shifted out. rd_data[16] stays 1 until completion.
- R10: After reset, rd_data is 0, spi_cs_n is 1, and spi_sclk and spi_mosi are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 32 | Word to store: payload 15:0, start 16, enable 17, free bits above |
| rd_data | output | 32 | Register readback, with bit 16 as the busy flag |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the codec |
| spi_cs_n | output | 1 | Active-low codec select |

## Verification
On every cycle the assertions check that the busy flag mirrors the select and that the clock idles low while deselected. They also check that data holds steady while the clock is high, that each select window holds exactly 16 rising clock edges, that busy rises only after an enabled host write, and that completion leaves the payload and upper bits untouched. Only the bench's scenarios can show the rest. These are the recovered bit order of real payload patterns, the serial clock period, and the absence of a transfer when the strobe is re-written high or the enable is clear. The scenarios also show that a write during a transfer changes the stored word without disturbing the bits on the wire.

// File: rtl/spi_strobe_pkg.sv
package spi_strobe_pkg;

  typedef enum logic [0:0] {
    SH_IDLE = 1'b0,
    SH_RUN  = 1'b1
  } shift_state_e;

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int HALF = CLK_DIV / 2;

  generate
    if (HALF <= 1) begin : g_every_cycle
      assign tick = run;
    end else begin : g_counted
      localparam int CW = $clog2(HALF);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (!run) begin
          cnt_q <= '0;
        end else if (cnt_q == CW'(HALF - 1)) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      assign tick = run && (cnt_q == CW'(HALF - 1));
    end
  endgenerate

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_strobe_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [DATA_W-1:0] payload,
  input  logic              tick,
  output logic              active,
  output logic              done,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n
);

  localparam int CNT_W = $clog2(DATA_W);

  shift_state_e      st_q;
  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  bit_q;
  logic              sclk_q;
  logic              cs_n_q;
  logic              last_bit;

  assign last_bit = (bit_q == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      sh_q   <= '0;
      bit_q  <= '0;
      sclk_q <= 1'b0;
      cs_n_q <= 1'b1;
    end else begin
      case (st_q)
        SH_IDLE: begin
          if (launch) begin
            st_q   <= SH_RUN;
            sh_q   <= payload;
            bit_q  <= '0;
            sclk_q <= 1'b0;
            cs_n_q <= 1'b0;
          end
        end
        SH_RUN: begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
            end else begin
              sclk_q <= 1'b0;
              if (last_bit) begin
                st_q   <= SH_IDLE;
                bit_q  <= '0;
                cs_n_q <= 1'b1;
              end else begin
                sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
                bit_q <= bit_q + 1'b1;
              end
            end
          end
        end
        default: st_q <= SH_IDLE;
      endcase
    end
  end

  assign active = (st_q == SH_RUN);
  assign done   = active && tick && sclk_q && last_bit;
  assign sclk   = sclk_q;
  assign cs_n   = cs_n_q;
  assign mosi   = active ? sh_q[DATA_W-1] : 1'b0;

endmodule

// File: rtl/spi_ctrl_reg.sv
module spi_ctrl_reg #(
  parameter int REG_W  = 32,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              done,
  output logic              launch,
  output logic [DATA_W-1:0] payload,
  output logic [REG_W-1:0]  rd_data
);

  localparam int STB_BIT = DATA_W;
  localparam int EN_BIT  = DATA_W + 1;

  logic [REG_W-1:0] reg_q;
  logic             host_stb_q;
  logic             busy;
  logic             stb_next;

  assign busy    = reg_q[STB_BIT];
  assign launch  = wr_en && wr_data[STB_BIT] && wr_data[EN_BIT] && !host_stb_q && !busy;
  assign payload = wr_data[DATA_W-1:0];

  always_comb begin
    stb_next = reg_q[STB_BIT];
    if (launch) begin
      stb_next = 1'b1;
    end else if (done) begin
      stb_next = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q      <= '0;
      host_stb_q <= 1'b0;
    end else begin
      if (wr_en) begin
        reg_q[REG_W-1:STB_BIT+1] <= wr_data[REG_W-1:STB_BIT+1];
        reg_q[DATA_W-1:0]        <= wr_data[DATA_W-1:0];
        host_stb_q               <= wr_data[STB_BIT];
      end
      reg_q[STB_BIT] <= stb_next;
    end
  end

  assign rd_data = reg_q;

endmodule

// File: rtl/spi_strobe_ctrl.sv
module spi_strobe_ctrl #(
  parameter int REG_W   = 32,
  parameter int DATA_W  = 16,
  parameter int CLK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             spi_sclk,
  output logic             spi_mosi,
  output logic             spi_cs_n
);

  logic              launch;
  logic              done;
  logic              active;
  logic              tick;
  logic [DATA_W-1:0] payload;

  spi_ctrl_reg #(
    .REG_W  (REG_W),
    .DATA_W (DATA_W)
  ) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .done    (done),
    .launch  (launch),
    .payload (payload),
    .rd_data (rd_data)
  );

  spi_clk_div #(
    .CLK_DIV (CLK_DIV)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (active),
    .tick  (tick)
  );

  spi_shifter #(
    .DATA_W (DATA_W)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (launch),
    .payload (payload),
    .tick    (tick),
    .active  (active),
    .done    (done),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .cs_n    (spi_cs_n)
  );

endmodule

// File: rtl/spi_strobe_ctrl_chk.sv
module spi_strobe_ctrl_chk #(
  parameter int REG_W  = 32,
  parameter int DATA_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             spi_sclk,
  input logic             spi_mosi,
  input logic             spi_cs_n
);

  localparam int STB = DATA_W;
  localparam int EN  = DATA_W + 1;
  localparam int EW  = $clog2(DATA_W + 1) + 1;

  logic          sclk_d;
  logic [EW-1:0] edge_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      edge_cnt <= '0;
    end else begin
      sclk_d <= spi_sclk;
      if (spi_cs_n) begin
        edge_cnt <= '0;
      end else if (spi_sclk && !sclk_d) begin
        edge_cnt <= edge_cnt + 1'b1;
      end
    end
  end

  assert_busy_tracks_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[STB] == !spi_cs_n);

  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  assert_mosi_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  assert_edge_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> (edge_cnt == EW'(DATA_W)));

  assert_launch_from_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[STB]) |-> ($past(wr_en) && $past(wr_data[STB])));

  assert_enable_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[STB]) |-> $past(wr_data[EN]));

  assert_complete_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_data[STB]) && !$past(wr_en)) |->
      (rd_data[REG_W-1:STB+1] == $past(rd_data[REG_W-1:STB+1]) &&
       rd_data[DATA_W-1:0] == $past(rd_data[DATA_W-1:0])));

endmodule

bind spi_strobe_ctrl spi_strobe_ctrl_chk #(
  .REG_W  (REG_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .spi_sclk (spi_sclk),
  .spi_mosi (spi_mosi),
  .spi_cs_n (spi_cs_n)
);

// File: tb/spi_strobe_ctrl_tb.sv
`timescale 1ns/1ps
module spi_strobe_ctrl_tb;

  localparam int DIV = 4;
  localparam logic [31:0] STB = 32'h0001_0000;
  localparam logic [31:0] EN  = 32'h0002_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        spi_sclk, spi_mosi, spi_cs_n;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;
  int rise_cnt = 0;
  int low_cyc = 0;
  int cs_falls = 0;
  int mode_viol = 0;
  logic [15:0] rx = '0;
  logic sclk_p = 1'b0;
  logic mosi_p = 1'b0;

  always #2 clk = ~clk;

  spi_strobe_ctrl #(.REG_W(32), .DATA_W(16), .CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
  );

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    rx = {rx[14:0], spi_mosi};
    rise_cnt++;
  end

  always @(negedge spi_cs_n) if (rst_n) cs_falls++;

  always @(negedge clk) begin
    if (spi_sclk && sclk_p && spi_mosi !== mosi_p) mode_viol++;
    if (spi_cs_n && spi_sclk) mode_viol++;
    if (!spi_cs_n) low_cyc++;
    sclk_p = spi_sclk;
    mosi_p = spi_mosi;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (rd_data[16] && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic clear_mon();
    rise_cnt = 0; low_cyc = 0; mode_viol = 0; rx = '0;
  endtask

  task automatic t_reset();
    chk("R10 rd_data after reset", rd_data, 32'h0);
    chk("R10 cs_n after reset", {31'b0, spi_cs_n}, 32'h1);
    chk("R10 sclk/mosi after reset", {30'b0, spi_sclk, spi_mosi}, 32'h0);
  endtask

  // full transfer; leaves the strobe set as last host write
  task automatic t_transfer(input logic [31:0] w);
    int n;
    logic [31:0] base;
    base = (w & ~STB) | EN;
    host_write(base);
    clear_mon();
    host_write(base | STB);
    chk("R5 busy after rising strobe", {31'b0, rd_data[16]}, 32'h1);
    wait_idle(n);
    chk("R4 completes in time", {31'b0, (n < 2000)}, 32'h1);
    @(negedge clk);
    chk("R1 bits received MSB first", {16'b0, rx}, {16'b0, base[15:0]});
    chk("R3 sclk rising edges", rise_cnt, 16);
    chk("R4 select low cycles", low_cyc, 16 * DIV);
    chk("R2 mode 0 violations", mode_viol, 0);
    chk("R7 R8 readback after completion", rd_data, base);
  endtask

  task automatic t_hold(input logic [31:0] w);
    int f0;
    f0 = cs_falls;
    host_write(((w & ~STB) | EN) | STB);
    repeat (100) @(negedge clk);
    chk("R5 strobe held high starts nothing", cs_falls - f0, 0);
    chk("R5 busy stays clear", {31'b0, rd_data[16]}, 32'h0);
  endtask

  task automatic t_no_enable();
    int f0;
    logic [31:0] w;
    w = 32'h5550_1234;
    w = w & ~(STB | EN);
    host_write(w);
    f0 = cs_falls;
    host_write(w | STB);
    repeat (100) @(negedge clk);
    chk("R6 no transfer without enable", cs_falls - f0, 0);
    chk("R6 strobe reads 0, rest kept", rd_data, w);
  endtask

  task automatic t_mid_write();
    int n;
    logic [31:0] a, b;
    a = 32'h0C02_C3A5;
    b = 32'hF00E_0F0F;
    host_write(a);
    clear_mon();
    host_write(a | STB);
    repeat (20) @(negedge clk);
    host_write(b);
    chk("R9 busy held during transfer", {31'b0, rd_data[16]}, 32'h1);
    chk("R9 stored bits updated", rd_data & ~STB, b);
    wait_idle(n);
    @(negedge clk);
    chk("R9 shifted data unaffected", {16'b0, rx}, {16'b0, a[15:0]});
    chk("R8 R7 final readback", rd_data, b);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_transfer(32'hDEAC_A55A);
    t_hold(32'hDEAC_A55A);
    t_transfer(32'h0000_8001);
    t_transfer(32'h7FFC_FFFF);
    t_transfer(32'hA5A4_0000);
    t_no_enable();
    t_mid_write();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule